// File: doc/BRIEF.md
# Phase-Continuous Hopping Quadrature Sine Synthesizer

This block is a pair of numerically controlled oscillators that share one phase accumulator. Its in-phase and quadrature sample streams feed the two inputs of a quadrature upconverter. A signed frequency-offset command, loaded on a hop strobe, sets the tuning word. A positive offset makes the accumulator phase rise, which places the output above the local oscillator. A negative offset is sign-extended into its two's-complement form and added in the same way, so the phase falls and the output moves below the local oscillator. No separate sideband selector or output combiner is needed.

A hop only replaces the increment. The accumulator keeps its contents, so the phase of both outputs runs on without a jump from one hop to the next. The ten most significant phase bits address a quarter-wave sine table that is folded into a full period. The in-phase channel reads a quarter turn ahead, which makes it a cosine. The quadrature channel reads the phase itself, which makes it a sine. The phase behind the current samples is also driven out, so a consumer or a test can follow the rotation.

Top module: `hop_quad_dds`

## Requirements
- R1: While reset is asserted, i_samp, q_samp and phase_o are all zero. After release, the increment stays zero until the first hop, so phase_o holds at 0 and the outputs hold at i_samp = 2047 and q_samp = 6.
- R2: When hop_stb is high at a rising clock edge, hop_ofs is taken as a 24-bit two's-complement number and sign-extended to a 32-bit increment. The first phase step that uses the new increment appears in phase_o two edges after the loading edge.
- R3: On every clock after release, phase_o moves by exactly the increment in force, modulo 2^32. A negative offset therefore makes phase_o count down.
- R4: While hop_stb is low, hop_ofs is ignored and the previous increment is kept.
- R5: A hop never writes the accumulator. Across any sequence of hops, including hops between positive and negative offsets on consecutive clocks, each consecutive difference of phase_o equals the increment in force for that step.
- R6: q_samp equals round(2047 * sin(2*pi*(a + 0.5)/1024)), within 1 LSB, where a = phase_o[31:22].
- R7: i_samp equals the same function evaluated at (a + 256) mod 1024, which is the cosine of the same phase. It is valid in the same cycle as q_samp and phase_o.
- R8: Neither sample output ever takes the value -2048. The waveform is symmetric about zero with a peak magnitude of 2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hop_stb | input | 1 | Load strobe for a new frequency offset |
| hop_ofs | input | 24 | Signed frequency offset, in two's complement |
| i_samp | output | 12 | In-phase (cosine) sample, signed |
| q_samp | output | 12 | Quadrature (sine) sample, signed |
| phase_o | output | 32 | Accumulator phase that the current samples were taken from |

## Verification
The bench first sweeps every table address with an offset of one address per clock, counting upward and then downward. This exposes any error in the quadrant mirror or the negation, and a wrong fold shows up as a sample that disagrees with the sine of its own phase. The bench then hops on consecutive clocks between extreme offsets, including -1, the most negative value and the most positive value. A design that cleared or reloaded the accumulator on a hop, truncated the offset instead of sign-extending it, or applied the new offset one cycle off would break the expected phase difference. It also drives noise on the offset while the strobe is low, which catches a design that loads the offset without waiting for the strobe.

// File: rtl/hqd_pkg.sv
package hqd_pkg;

  // Quarter-wave sine magnitude at the midpoint of table slot idx, evaluated
  // at elaboration with a truncated power series (error far below 1 LSB).
  function automatic int sine_mag(input int idx, input int qtr, input int amp);
    real x;
    real term;
    real acc;
    x    = 1.5707963267948966 * (real'(idx) + 0.5) / real'(qtr);
    term = x;
    acc  = x;
    for (int k = 1; k < 10; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return $rtoi(acc * real'(amp) + 0.5);
  endfunction

endpackage

// File: rtl/hqd_rst_sync.sv
module hqd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/hqd_tune.sv
module hqd_tune #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [OFS_W-1:0] ofs,
  output logic [ACC_W-1:0] inc
);
  logic [ACC_W-1:0] ext_w;
  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] inc_d;

  generate
    if (ACC_W > OFS_W) begin : g_ext
      assign ext_w = {{(ACC_W - OFS_W){ofs[OFS_W-1]}}, ofs};
    end else begin : g_same
      assign ext_w = ofs[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    inc_d = inc_q;
    if (load_en) inc_d = ext_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_q <= '0;
    else        inc_q <= inc_d;
  end

  assign inc = inc_q;
endmodule

// File: rtl/hqd_accum.sv
module hqd_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  // Modular add: a two's-complement increment turns this into a decrement.
  always_comb acc_d = acc_q + inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase = acc_q;
endmodule

// File: rtl/hqd_sine_lut.sv
module hqd_sine_lut #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SAMP_W-1:0] samp
);
  import hqd_pkg::*;

  localparam int QA_W  = ADDR_W - 2;
  localparam int QTR   = 2 ** QA_W;
  localparam int MAG_W = SAMP_W - 1;
  localparam int AMP   = 2 ** MAG_W - 1;

  logic [MAG_W-1:0] rom [QTR];

  generate
    for (genvar j = 0; j < QTR; j++) begin : g_rom
      localparam int VAL = sine_mag(j, QTR, AMP);
      assign rom[j] = VAL[MAG_W-1:0];
    end
  endgenerate

  logic [1:0]       quad;
  logic [QA_W-1:0]  idx;
  logic [QA_W-1:0]  sel;
  logic [MAG_W-1:0] mag;

  always_comb begin
    quad = addr[ADDR_W-1 -: 2];
    idx  = addr[QA_W-1:0];
    sel  = quad[0] ? ~idx : idx;
    mag  = rom[sel];
    samp = quad[1] ? (SAMP_W'(0) - {1'b0, mag}) : {1'b0, mag};
  end
endmodule

// File: rtl/hop_quad_dds.sv
module hop_quad_dds #(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 24,
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hop_stb,
  input  logic [OFS_W-1:0]  hop_ofs,
  output logic [SAMP_W-1:0] i_samp,
  output logic [SAMP_W-1:0] q_samp,
  output logic [ACC_W-1:0]  phase_o
);
  localparam logic [ADDR_W-1:0] QTURN = ADDR_W'(1) << (ADDR_W - 2);

  logic             rst_sync_n;
  logic [ACC_W-1:0] inc_w;
  logic [ACC_W-1:0] acc_w;
  logic [SAMP_W-1:0] lut_w [2];

  hqd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  hqd_tune #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_tune (
    .clk(clk), .rst_n(rst_sync_n), .load_en(hop_stb), .ofs(hop_ofs), .inc(inc_w)
  );

  hqd_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc_w), .phase(acc_w)
  );

  // Channel 0 = in-phase (quarter turn ahead, cosine), channel 1 = quadrature.
  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      logic [ADDR_W-1:0] addr_w;
      assign addr_w = acc_w[ACC_W-1 -: ADDR_W] + ((ch == 0) ? QTURN : '0);
      hqd_sine_lut #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_lut (
        .addr(addr_w), .samp(lut_w[ch])
      );
    end
  endgenerate

  logic [SAMP_W-1:0] i_d, q_d, i_q, q_q;
  logic [ACC_W-1:0]  ph_d, ph_q;

  always_comb begin
    i_d  = lut_w[0];
    q_d  = lut_w[1];
    ph_d = acc_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      i_q  <= '0;
      q_q  <= '0;
      ph_q <= '0;
    end else begin
      i_q  <= i_d;
      q_q  <= q_d;
      ph_q <= ph_d;
    end
  end

  assign i_samp  = i_q;
  assign q_samp  = q_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/hop_quad_dds_chk.sv
module hop_quad_dds_chk #(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 24,
  parameter int SAMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hop_stb,
  input logic [OFS_W-1:0]  hop_ofs,
  input logic [ACC_W-1:0]  inc,
  input logic [SAMP_W-1:0] i_samp,
  input logic [SAMP_W-1:0] q_samp,
  input logic [ACC_W-1:0]  phase_o
);
  localparam logic [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (phase_o == '0 && i_samp == '0 && q_samp == '0));

  // R2
  hop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd0 && hop_stb) |=>
      (inc == ACC_W'($signed($past(hop_ofs)))));

  // R4
  hold_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd0 && !hop_stb) |=> $stable(inc));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (phase_o - $past(phase_o) == $past(inc, 2)));

  // R8
  no_most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_samp != MOST_NEG && q_samp != MOST_NEG));
endmodule

bind hop_quad_dds hop_quad_dds_chk #(.ACC_W(ACC_W), .OFS_W(OFS_W), .SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .hop_stb(hop_stb), .hop_ofs(hop_ofs),
  .inc(inc_w), .i_samp(i_samp), .q_samp(q_samp), .phase_o(phase_o)
);

// File: tb/hop_quad_dds_tb.sv
module hop_quad_dds_tb;
  logic        clk;
  logic        rst_n;
  logic        hop_stb;
  logic [23:0] hop_ofs;
  logic [11:0] i_samp, q_samp;
  logic [31:0] phase_o;

  int tests, fails;
  bit done;

  logic [31:0] h0, h1, h2, prev_ph;

  hop_quad_dds u_dut (
    .clk(clk), .rst_n(rst_n), .hop_stb(hop_stb), .hop_ofs(hop_ofs),
    .i_samp(i_samp), .q_samp(q_samp), .phase_o(phase_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_samp(input int a);
    real v;
    v = 2047.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk_samples();
    int a, ei, eq, ai, aq;
    a  = int'(phase_o[31:22]);
    eq = ref_samp(a);
    ei = ref_samp((a + 256) % 1024);
    ai = int'($signed(i_samp));
    aq = int'($signed(q_samp));
    chk((aq - eq <= 1) && (eq - aq <= 1), "R6 q_samp", aq, eq);
    chk((ai - ei <= 1) && (ei - ai <= 1), "R7 i_samp", ai, ei);
    chk(i_samp != 12'h800 && q_samp != 12'h800, "R8 most-negative code", ai, aq);
  endtask

  // Called at a falling edge; passes one rising edge and samples at the next falling edge.
  task automatic step(input bit stb, input logic [23:0] ofs, input string tag);
    logic [31:0] diff;
    hop_stb = stb;
    hop_ofs = ofs;
    @(negedge clk);
    h2 = h1;
    h1 = h0;
    if (stb) h0 = {{8{ofs[23]}}, ofs};
    diff = phase_o - prev_ph;
    chk(diff == h2, tag, longint'(diff), longint'(h2));
    prev_ph = phase_o;
    chk_samples();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0; hop_stb = 1'b0; hop_ofs = 24'h5A5A5A;
    h0 = '0; h1 = '0; h2 = '0; prev_ph = '0;
    repeat (4) @(negedge clk);
    chk(phase_o == 0, "R1 phase in reset", phase_o, 0);
    chk(i_samp == 0, "R1 i in reset", i_samp, 0);
    chk(q_samp == 0, "R1 q in reset", q_samp, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(phase_o == 0, "R1 idle phase", phase_o, 0);
      chk($signed(i_samp) == 2047, "R1 idle i", $signed(i_samp), 2047);
      chk($signed(q_samp) == 6, "R1 idle q", $signed(q_samp), 6);
      @(negedge clk);
    end
    // R3: count up one table slot per clock across all addresses
    step(1'b1, 24'h400000, "R3 up sweep");
    for (int k = 0; k < 1030; k++) step(1'b0, 24'h000000, "R3 up sweep");
    // R3: count down one table slot per clock
    step(1'b1, 24'hC00000, "R3 down sweep");
    for (int k = 0; k < 1030; k++) step(1'b0, 24'h000000, "R3 down sweep");
    // R2 / R5: hops on consecutive clocks between extreme signed offsets
    step(1'b1, 24'hFFFFFF, "R2 hop to -1");
    step(1'b1, 24'h7FFFFF, "R2 hop to max");
    step(1'b1, 24'h800000, "R2 hop to min");
    step(1'b1, 24'h000001, "R5 hop to +1");
    step(1'b1, 24'h3039A1, "R5 hop positive");
    step(1'b0, 24'h000000, "R5 settle");
    step(1'b0, 24'h000000, "R5 settle");
    for (int k = 0; k < 200; k++) begin
      logic [23:0] o;
      o = 24'((k * 32'h9E3779B1) ^ (k << 7));
      step((k % 3) != 2, o, "R5 hop chain");
    end
    // R4: offset noise with strobe low
    for (int k = 0; k < 300; k++) begin
      logic [23:0] o;
      o = 24'(k * 32'h01234567 + 32'h00ABCDEF);
      step(1'b0, o, "R4 strobe low");
    end
    // R5: long run after a negative hop, crossing the zero phase
    step(1'b1, 24'hF12345, "R5 negative run");
    for (int k = 0; k < 400; k++) step(1'b0, 24'h000000, "R5 negative run");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule